// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive half of one isochronous OUT endpoint in a full-speed USB device controller. The serial engine delivers data that is already decoded. A packet arrives as a start strobe, then one strobe per data byte, then an end strobe that carries a good/bad verdict. The block admits a packet only when a whole maximum-size packet fits in storage. Accepted bytes are held tentatively until the end strobe. A good packet is committed. A bad or oversize packet is rolled back so that no trace of it remains. The storage holds two packets, so the processor can drain one while the next arrives.

The processor sees a control/status word and a byte read port. Each read strobe pops one byte of committed data. All status bits track whole packets. Packet-complete and overflow are sticky and are cleared by writing 1 to them. The short-packet flag clears itself when the next packet starts. Isochronous traffic is never refused with a handshake, so a packet that does not fit is dropped in full and reported through the overflow flag. An interrupt request is raised while packet-complete is set and the enable input is high.

The receive controller is a three-state machine:
- `RX_IDLE`: waiting for a packet start.
- `RX_FILL`: storing the bytes of an admitted packet.
- `RX_DISCARD`: ignoring the bytes of a refused or oversize packet.

Its transitions are:
- start with room: any state to `RX_FILL`. A start seen in `RX_FILL` first rolls back the unfinished packet.
- start without room: any state to `RX_DISCARD`, and the overflow flag is set.
- byte past maximum size: `RX_FILL` to `RX_DISCARD`, with rollback.
- end strobe: any state to `RX_IDLE`. In `RX_FILL` this either commits the packet (good) or rolls it back (bad).

Top module: `iso_out_rx`

## Requirements
- R1: After reset the status word reads 0 and the interrupt request is low.
- R2: The status word places its flags at fixed positions: bit 0 packet-ready, bit 1 packet-complete, bit 2 overflow, bit 6 not-empty, bit 7 short-packet. Bits 5:3 and 31:8 always read 0.
- R3: Not-empty (bit 6) is 1 whenever any byte is held, including the bytes of a packet still arriving. It is 0 when storage is empty.
- R4: Packet-ready (bit 0) is 1 while at least one complete good packet is held. It drops on the clock edge that pops the last byte of the last held packet.
- R5: A good end strobe sets packet-complete (bit 1) on that clock edge. The bit stays set until a status write with bit 1 set. A write with bit 1 clear has no effect on it.
- R6: Short-packet (bit 7) is set by a good packet shorter than MAX_PKT bytes. A full-size packet does not set it. It clears on the next start strobe, whether or not that packet is stored.
- R7: A start strobe is refused when free storage is below MAX_PKT bytes or two packets are already held. The whole packet is then dropped and overflow (bit 2) is set. Overflow clears only by a status write with bit 2 set.
- R8: A packet ended with the bad verdict is discarded. Its bytes are removed from storage and packet-complete is not set.
- R9: A packet carrying more than MAX_PKT bytes is discarded like a bad packet.
- R10: Each read strobe pops one byte, in arrival order. A read strobe while no complete packet is held has no effect.
- R11: The interrupt request equals packet-complete AND the interrupt-enable input.
- R12: Two packets can be held at once. Their bytes and boundaries are preserved across both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sop | input | 1 | Packet start strobe from the serial engine |
| rx_byte_vld | input | 1 | Data byte strobe |
| rx_byte | input | 8 | Data byte |
| rx_eop | input | 1 | Packet end strobe |
| rx_good | input | 1 | Verdict qualifying rx_eop (1 = good) |
| rd_pop | input | 1 | Processor read strobe, pops one byte |
| rd_data | output | 8 | Byte at the head of storage |
| csr_wr | input | 1 | Status write strobe (write 1 to clear) |
| csr_wdata | input | 32 | Status write data |
| csr_rdata | output | 32 | Status word |
| irq_en | input | 1 | Interrupt enable for this endpoint |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check, on every cycle, invariants that hold regardless of traffic. Packet-ready never appears without stored bytes. Overflow and packet-complete rise only after a start strobe or a good end strobe, and fall only after a matching clearing write. Short-packet falls only at a start strobe. Storage never exceeds two packets or MAX_PKT bytes per packet. Only the bench scenarios can show the effects of whole packets: byte order and packet boundaries, that bad and oversize packets leave storage empty, the exact edge on which packet-ready drops, and which packet lengths set short-packet.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_FILL    = 2'd1,
        RX_DISCARD = 2'd2
    } rx_state_e;

    localparam int CSR_RDY   = 0;
    localparam int CSR_DONE  = 1;
    localparam int CSR_OVF   = 2;
    localparam int CSR_AVAIL = 6;
    localparam int CSR_SHORT = 7;
endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          commit,
    input  logic          rollback,
    input  logic          pop,
    output logic [7:0]    head_data,
    output logic [AW:0]   used_commit,
    output logic [AW:0]   used_total
);
    logic [7:0]  mem [DEPTH];
    logic [AW:0] wr_ptr, cm_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end else if (rollback) begin
                wr_ptr <= cm_ptr;
            end
            if (commit) begin
                cm_ptr <= wr_ptr;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    assign head_data   = mem[rd_ptr[AW-1:0]];
    assign used_commit = cm_ptr - rd_ptr;
    assign used_total  = wr_ptr - rd_ptr;

    // R12: the storage never holds more than its two-packet capacity
    assert_store_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        used_total <= (AW+1)'(DEPTH));
    // R10: a pop only consumes committed data
    assert_pop_committed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> used_commit != '0);
endmodule

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
    import iso_rx_pkg::*;
#(
    parameter int MAX_PKT = 256,
    parameter int DEPTH   = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sop,
    input  logic          byte_vld,
    input  logic          eop,
    input  logic          good,
    input  logic [AW:0]   used_commit,
    input  logic [1:0]    pkt_cnt,
    output logic          push,
    output logic          commit,
    output logic          rollback,
    output logic          set_done,
    output logic          set_ovf,
    output logic          set_short,
    output logic          clr_short,
    output logic          q_push,
    output logic [LW-1:0] q_len
);
    localparam logic [AW:0]   ROOM_LIMIT = (AW+1)'(DEPTH - MAX_PKT);
    localparam logic [LW-1:0] MAX_LEN    = LW'(MAX_PKT);

    rx_state_e     state_q, state_n;
    logic [LW-1:0] cnt_q, cnt_n;
    logic          room;

    assign room  = (used_commit <= ROOM_LIMIT) && (pkt_cnt < 2'd2);
    assign q_len = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        push      = 1'b0;
        commit    = 1'b0;
        rollback  = 1'b0;
        set_done  = 1'b0;
        set_ovf   = 1'b0;
        set_short = 1'b0;
        clr_short = 1'b0;
        q_push    = 1'b0;
        if (sop) begin
            clr_short = 1'b1;
            rollback  = (state_q == RX_FILL);
            cnt_n     = '0;
            if (room) begin
                state_n = RX_FILL;
            end else begin
                state_n = RX_DISCARD;
                set_ovf = 1'b1;
            end
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    state_n = RX_IDLE;
                end
                RX_FILL: begin
                    if (eop) begin
                        state_n = RX_IDLE;
                        if (good) begin
                            set_done  = 1'b1;
                            set_short = (cnt_q < MAX_LEN);
                            commit    = (cnt_q != '0);
                            q_push    = (cnt_q != '0);
                        end else begin
                            rollback = 1'b1;
                        end
                    end else if (byte_vld) begin
                        if (cnt_q == MAX_LEN) begin
                            rollback = 1'b1;
                            state_n  = RX_DISCARD;
                        end else begin
                            push  = 1'b1;
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                RX_DISCARD: begin
                    if (eop) begin
                        state_n = RX_IDLE;
                    end
                end
                default: state_n = RX_IDLE;
            endcase
        end
    end

    // R9: no packet ever stores more than MAX_PKT bytes
    assert_no_oversize_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> cnt_q < MAX_LEN);
    // R7: a refused packet stores nothing until the next start strobe
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> !push);
endmodule

// File: rtl/iso_rx_pktq.sv
module iso_rx_pktq #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_push,
    input  logic [LW-1:0] q_len,
    input  logic          rd_fire,
    output logic [1:0]    pkt_cnt,
    output logic          last_rd
);
    logic [LW-1:0] len_q [2];
    logic          wr_i, rd_i;
    logic [LW-1:0] rd_cnt;

    assign last_rd = rd_fire && ((rd_cnt + LW'(1)) == len_q[rd_i]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q[0] <= '0;
            len_q[1] <= '0;
            wr_i     <= 1'b0;
            rd_i     <= 1'b0;
            rd_cnt   <= '0;
            pkt_cnt  <= '0;
        end else begin
            if (q_push) begin
                len_q[wr_i] <= q_len;
                wr_i        <= ~wr_i;
            end
            if (last_rd) begin
                rd_cnt <= '0;
                rd_i   <= ~rd_i;
            end else if (rd_fire) begin
                rd_cnt <= rd_cnt + 1'b1;
            end
            unique case ({q_push, last_rd})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

    // R12: at most two packets are ever held
    assert_pkt_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> pkt_cnt != 2'd2);
    // R10: reads only complete a packet that exists
    assert_read_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        last_rd |-> pkt_cnt != 2'd0);
endmodule

// File: rtl/iso_out_rx.sv
module iso_out_rx
    import iso_rx_pkg::*;
#(
    parameter int MAX_PKT = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sop,
    input  logic        rx_byte_vld,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eop,
    input  logic        rx_good,
    input  logic        rd_pop,
    output logic [7:0]  rd_data,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        irq_en,
    output logic        irq
);
    localparam int DEPTH = 2 * MAX_PKT;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(MAX_PKT + 1);

    logic          push, commit, rollback, set_done, set_ovf, set_short, clr_short;
    logic          q_push, last_rd, rd_fire;
    logic [LW-1:0] q_len;
    logic [1:0]    pkt_cnt;
    logic [AW:0]   used_commit, used_total;
    logic          done_q, ovf_q, short_q, rdy, avail;
    logic          unused_wbits;

    assign unused_wbits = ^{csr_wdata[31:3], csr_wdata[0]};
    assign rd_fire      = rd_pop && (pkt_cnt != 2'd0);

    iso_rx_ctrl #(.MAX_PKT(MAX_PKT), .DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sop(rx_sop), .byte_vld(rx_byte_vld),
        .eop(rx_eop), .good(rx_good), .used_commit(used_commit), .pkt_cnt(pkt_cnt),
        .push(push), .commit(commit), .rollback(rollback), .set_done(set_done),
        .set_ovf(set_ovf), .set_short(set_short), .clr_short(clr_short),
        .q_push(q_push), .q_len(q_len)
    );

    iso_rx_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_byte),
        .commit(commit), .rollback(rollback), .pop(rd_fire),
        .head_data(rd_data), .used_commit(used_commit), .used_total(used_total)
    );

    iso_rx_pktq #(.LW(LW)) pktq_i (
        .clk(clk), .rst_n(rst_n), .q_push(q_push), .q_len(q_len),
        .rd_fire(rd_fire), .pkt_cnt(pkt_cnt), .last_rd(last_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
            short_q <= 1'b0;
        end else begin
            if (set_done) begin
                done_q <= 1'b1;
            end else if (csr_wr && csr_wdata[CSR_DONE]) begin
                done_q <= 1'b0;
            end
            if (set_ovf) begin
                ovf_q <= 1'b1;
            end else if (csr_wr && csr_wdata[CSR_OVF]) begin
                ovf_q <= 1'b0;
            end
            if (set_short) begin
                short_q <= 1'b1;
            end else if (clr_short) begin
                short_q <= 1'b0;
            end
        end
    end

    assign rdy   = (pkt_cnt != 2'd0);
    assign avail = (used_total != '0);

    always_comb begin
        csr_rdata            = '0;
        csr_rdata[CSR_RDY]   = rdy;
        csr_rdata[CSR_DONE]  = done_q;
        csr_rdata[CSR_OVF]   = ovf_q;
        csr_rdata[CSR_AVAIL] = avail;
        csr_rdata[CSR_SHORT] = short_q;
    end

    assign irq = done_q && irq_en;

    // R4: a ready packet implies bytes are held
    assert_ready_has_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[CSR_RDY] |-> csr_rdata[CSR_AVAIL]);
    // R5: packet-complete rises only after a good end strobe
    assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[CSR_DONE]) |-> $past(rx_eop && rx_good));
    // R7: overflow rises only after a start strobe
    assert_ovf_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[CSR_OVF]) |-> $past(rx_sop));
    // R7: overflow falls only after a clearing write
    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[CSR_OVF]) |-> $past(csr_wr && csr_wdata[CSR_OVF]));
    // R6: short-packet falls only when a new packet starts
    assert_short_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_rdata[CSR_SHORT]) |-> $past(rx_sop));
endmodule

// File: tb/iso_out_rx_tb.sv
module iso_out_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sop = 1'b0, rx_byte_vld = 1'b0, rx_eop = 1'b0, rx_good = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rd_pop = 1'b0;
    logic [7:0]  rd_data;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq_en = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_out_rx #(.MAX_PKT(MAXP)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_good(rx_good), .rd_pop(rd_pop),
        .rd_data(rd_data), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input int len, input bit good, input int base);
        rx_sop = 1'b1;
        @(negedge clk);
        rx_sop = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_byte_vld = 1'b1;
            rx_byte     = 8'(base + i);
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        rx_eop      = 1'b1;
        rx_good     = good;
        @(negedge clk);
        rx_eop = 1'b0;
    endtask

    task automatic read_bytes(input int n, input int base, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(tag, int'(rd_data), (base + i) % 256);
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
    endtask

    task automatic wclr(input logic [31:0] v);
        csr_wr    = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 status after reset", int'(csr_rdata), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // Sweep every length with both interrupt-enable settings
        for (int en = 0; en < 2; en++) begin
            for (int len = 1; len <= MAXP; len++) begin
                irq_en = en[0];
                send(len, 1'b1, len * 16 + en);
                chk("R4 ready after good packet", int'(csr_rdata[0]), 1);
                chk("R5 complete set", int'(csr_rdata[1]), 1);
                chk("R3 not-empty set", int'(csr_rdata[6]), 1);
                chk("R6 short for length", int'(csr_rdata[7]), (len < MAXP) ? 1 : 0);
                chk("R2 reserved bits zero", int'(csr_rdata & 32'hFFFF_FF38), 0);
                chk("R11 irq follows enable", int'(irq), en);
                read_bytes(len, len * 16 + en, "R10 byte order");
                chk("R4 ready cleared", int'(csr_rdata[0]), 0);
                chk("R3 not-empty cleared", int'(csr_rdata[6]), 0);
                wclr(32'hFFFF_FFF9);
                chk("R5 write without bit1 keeps complete", int'(csr_rdata[1]), 1);
                wclr(32'h0000_0002);
                chk("R5 complete cleared", int'(csr_rdata[1]), 0);
                chk("R11 irq low after clear", int'(irq), 0);
            end
        end
        irq_en = 1'b0;

        // Partial then bad verdict
        rx_sop = 1'b1;
        @(negedge clk);
        rx_sop = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rx_byte_vld = 1'b1;
            rx_byte = 8'(i);
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        chk("R3 not-empty during arrival", int'(csr_rdata[6]), 1);
        chk("R4 not ready during arrival", int'(csr_rdata[0]), 0);
        rx_eop = 1'b1;
        rx_good = 1'b0;
        @(negedge clk);
        rx_eop = 1'b0;
        chk("R8 bad packet removed", int'(csr_rdata[6]), 0);
        chk("R8 no complete for bad", int'(csr_rdata[1]), 0);

        // Oversize
        send(MAXP + 1, 1'b1, 7);
        chk("R9 oversize removed", int'(csr_rdata[6]), 0);
        chk("R9 no complete for oversize", int'(csr_rdata[1]), 0);
        chk("R9 no overflow for oversize", int'(csr_rdata[2]), 0);

        // Storage full: third max packet dropped
        send(MAXP, 1'b1, 100);
        send(MAXP, 1'b1, 150);
        chk("R7 no overflow with room", int'(csr_rdata[2]), 0);
        send(MAXP, 1'b1, 200);
        chk("R7 overflow when full", int'(csr_rdata[2]), 1);
        read_bytes(MAXP, 100, "R12 first packet");
        chk("R12 second still ready", int'(csr_rdata[0]), 1);
        read_bytes(MAXP, 150, "R12 second packet");
        chk("R7 dropped packet absent", int'(csr_rdata[6]), 0);
        wclr(32'h0000_0002);
        chk("R7 overflow sticky", int'(csr_rdata[2]), 1);
        wclr(32'h0000_0004);
        chk("R7 overflow cleared", int'(csr_rdata[2]), 0);

        // Packet-count limit with plenty of byte room
        send(1, 1'b1, 40);
        send(2, 1'b1, 50);
        chk("R6 short set by short packet", int'(csr_rdata[7]), 1);
        send(1, 1'b1, 60);
        chk("R7 overflow at two packets", int'(csr_rdata[2]), 1);
        chk("R6 short cleared by dropped start", int'(csr_rdata[7]), 0);
        read_bytes(1, 40, "R12 short first");
        read_bytes(2, 50, "R12 short second");
        chk("R10 all drained", int'(csr_rdata[6]), 0);
        wclr(32'h0000_0006);

        // Short cleared by following full packet
        send(3, 1'b1, 70);
        chk("R6 short after 3 bytes", int'(csr_rdata[7]), 1);
        send(MAXP, 1'b1, 80);
        chk("R6 short cleared by full packet", int'(csr_rdata[7]), 0);
        read_bytes(3, 70, "R12 mixed first");
        read_bytes(MAXP, 80, "R12 mixed second");

        // Read strobes while empty are ignored
        for (int i = 0; i < 3; i++) begin
            rd_pop = 1'b1;
            @(negedge clk);
        end
        rd_pop = 1'b0;
        send(4, 1'b1, 90);
        read_bytes(3, 90, "R10 after empty reads");
        chk("R4 ready until last byte", int'(csr_rdata[0]), 1);
        read_bytes(1, 93, "R10 last byte");
        chk("R4 ready drops after last byte", int'(csr_rdata[0]), 0);
        chk("R3 empty at end", int'(csr_rdata[6]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule